// File: doc/BRIEF.md
# Serial Peripheral Slave Port with Receive and Transmit Queues

This block is the slave end of a four-wire SPI link, paired with a small host-side queue interface. The host preloads outgoing bytes into an 8-entry transmit queue and drains incoming bytes from an 8-entry receive queue. Each serial frame is 8 bits long and is shifted most significant bit first. The serial pins are sampled into the system clock domain, so the serial clock must stay below one twelfth of the system clock.

The block supports the two clock-polarity-0 timing variants, chosen by a phase input. In leading-phase mode the select line must be toggled for every byte: while select stays low, only the first byte is taken. In trailing-phase mode the select line may stay low across any number of back-to-back bytes. A host output-release control lets another slave share the data-out wire. The receive-level interrupt is raised once four bytes are waiting. Two sticky error flags report transmit starvation and receive loss. Decoding a device address carried in the bytes is left to host software.

Top module: `spi_slave_fifo`

## Requirements
- R1: After reset both queues are empty (`tx_empty`=1, `rx_empty`=1, `rx_level`=0). `irq`, `err_underrun`, `err_overrun` and `spi_miso_oe` are all 0.
- R2: With `cfg_cpha`=0 the slave presents bit 7 of the next transmit entry after select falls. It changes `spi_miso` on falling clock edges and samples `spi_mosi` on rising edges, MSB first. Each select period exchanges one byte and pops one transmit entry.
- R3: With `cfg_cpha`=0 and select held low across several bytes, only the first byte is written to the receive queue, and only one transmit entry is consumed.
- R4: With `cfg_cpha`=1 the slave launches data on rising edges and samples on falling edges. A held select exchanges consecutive bytes, and transmit entries leave and receive entries arrive in first-in first-out order.
- R5: `irq` becomes 1 one cycle after `rx_level` reaches 4 or more, and stays 1 until the host pulses `sts_clr` while `rx_level` is below 4. A level of 3 does not raise it.
- R6: A frame that starts while the transmit queue is empty shifts out all zeros and sets `err_underrun`.
- R7: A byte completed while the receive queue holds 8 entries is discarded and sets `err_overrun`. The 8 stored entries are unchanged.
- R8: While `cfg_sdo_off`=1, `spi_miso_oe` is 0 even when selected.
- R9: With `cfg_sdo_off`=0, `spi_miso_oe` is 1 while select is low and returns to 0 after select rises.
- R10: A one-cycle `sts_clr` pulse clears `err_underrun`, `err_overrun` and a no-longer-pending `irq`.
- R11: A push into a full transmit queue (`tx_full`=1) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpha | input | 1 | Clock phase: 0 leading-edge sample, 1 trailing-edge sample |
| cfg_sdo_off | input | 1 | Release the serial output line |
| tx_wr | input | 1 | Push `tx_wdata` into the transmit queue |
| tx_wdata | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue holds 8 entries |
| tx_empty | output | 1 | Transmit queue holds no entry |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_rdata | output | 8 | Head of the receive queue (valid while not empty) |
| rx_empty | output | 1 | Receive queue holds no entry |
| rx_full | output | 1 | Receive queue holds 8 entries |
| rx_level | output | 4 | Number of entries in the receive queue |
| sts_clr | input | 1 | Clear sticky flags and a released interrupt |
| err_underrun | output | 1 | Sticky: frame started with an empty transmit queue |
| err_overrun | output | 1 | Sticky: received byte dropped on a full queue |
| irq | output | 1 | Receive threshold interrupt |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (0 = line released) |

## Verification
The assertions watch, on every cycle, that the output enable stays low whenever release is requested or select has been high long enough to pass the synchronizer. They also check that the interrupt follows the receive level, that the level never passes the queue depth, and that each sticky error appears only when its queue was empty or full. Only the bench scenarios can show the serial bit order, the single-capture rule of a held select in leading phase, the queue ordering across a held select in trailing phase, and the zero fill on starvation. These depend on whole frames clocked by a master.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
    parameter int FRAME_W = 8;
    localparam int BIT_W = $clog2(FRAME_W);

    typedef enum logic { PH_LEAD = 1'b0, PH_TRAIL = 1'b1 } phase_e;

    typedef struct packed {
        logic [BIT_W-1:0]   bit_idx;
        logic               held;
        logic [FRAME_W-1:0] rx_sh;
        logic [FRAME_W-1:0] tx_sh;
        logic               sdo;
        logic               sdo_en;
        logic               sclk_prev;
        logic               sel_prev;
    } eng_t;

    typedef struct packed {
        logic underrun;
        logic overrun;
        logic irq;
    } flags_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int           W      = 3,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] INIT   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        logic [W-1:0] src;
        if (gi == 0) begin : g_first
            assign src = din;
        end else begin : g_next
            assign src = stg[gi-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[gi] <= INIT;
            else        stg[gi] <= src;
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_slv_fifo.sv
module spi_slv_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != CW'(DEPTH));
        do_pop  = pop  && (q.cnt != '0);
        if (do_push) d.wp = (q.wp == AW'(DEPTH-1)) ? '0 : q.wp + 1'b1;
        if (do_pop)  d.rp = (q.rp == AW'(DEPTH-1)) ? '0 : q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= wdata;
    end

    assign rdata = mem[q.rp];
    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign level = q.cnt;
endmodule

// File: rtl/spi_slv_engine.sv
module spi_slv_engine
    import spi_slv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sel_s,
    input  logic               sdi_s,
    input  logic               phase,
    input  logic               out_dis,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               tx_empty,
    output logic               tx_pop,
    output logic               rx_push,
    output logic [FRAME_W-1:0] rx_word,
    output logic               underrun_set,
    output logic               sdo,
    output logic               sdo_en
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    eng_t q, d;
    logic rise, fall, sel_start;
    logic [FRAME_W-1:0] load_word;
    phase_e ph;

    always_comb begin
        d            = q;
        tx_pop       = 1'b0;
        rx_push      = 1'b0;
        underrun_set = 1'b0;
        ph           = phase_e'(phase);
        rise         = sclk_s && !q.sclk_prev;
        fall         = !sclk_s && q.sclk_prev;
        sel_start    = sel_s && !q.sel_prev;
        load_word    = tx_empty ? '0 : tx_word;
        rx_word      = {q.rx_sh[FRAME_W-2:0], sdi_s};

        d.sclk_prev  = sclk_s;
        d.sel_prev   = sel_s;
        d.sdo_en     = sel_s && !out_dis;

        if (!sel_s) begin
            d.bit_idx = '0;
            d.held    = 1'b0;
        end else if (ph == PH_LEAD) begin
            if (sel_start) begin
                tx_pop       = !tx_empty;
                underrun_set = tx_empty;
                d.sdo        = load_word[FRAME_W-1];
                d.tx_sh      = load_word << 1;
                d.bit_idx    = '0;
                d.held       = 1'b0;
            end else if (!q.held) begin
                if (rise) begin
                    d.rx_sh = rx_word;
                    if (q.bit_idx == LAST_BIT) begin
                        rx_push   = 1'b1;
                        d.held    = 1'b1;
                        d.bit_idx = '0;
                    end else begin
                        d.bit_idx = q.bit_idx + 1'b1;
                    end
                end else if (fall && q.bit_idx != '0) begin
                    d.sdo   = q.tx_sh[FRAME_W-1];
                    d.tx_sh = q.tx_sh << 1;
                end
            end
        end else begin
            if (rise) begin
                if (q.bit_idx == '0) begin
                    tx_pop       = !tx_empty;
                    underrun_set = tx_empty;
                    d.sdo        = load_word[FRAME_W-1];
                    d.tx_sh      = load_word << 1;
                end else begin
                    d.sdo   = q.tx_sh[FRAME_W-1];
                    d.tx_sh = q.tx_sh << 1;
                end
            end else if (fall) begin
                d.rx_sh = rx_word;
                if (q.bit_idx == LAST_BIT) begin
                    rx_push   = 1'b1;
                    d.bit_idx = '0;
                end else begin
                    d.bit_idx = q.bit_idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo    = q.sdo;
    assign sdo_en = q.sdo_en;
endmodule

// File: rtl/spi_slave_fifo.sv
module spi_slave_fifo
    import spi_slv_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int IRQ_LEVEL = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_cpha,
    input  logic                    cfg_sdo_off,
    input  logic                    tx_wr,
    input  logic [FRAME_W-1:0]      tx_wdata,
    output logic                    tx_full,
    output logic                    tx_empty,
    input  logic                    rx_rd,
    output logic [FRAME_W-1:0]      rx_rdata,
    output logic                    rx_empty,
    output logic                    rx_full,
    output logic [$clog2(DEPTH):0]  rx_level,
    input  logic                    sts_clr,
    output logic                    err_underrun,
    output logic                    err_overrun,
    output logic                    irq,
    input  logic                    spi_sclk,
    input  logic                    spi_cs_n,
    input  logic                    spi_mosi,
    output logic                    spi_miso,
    output logic                    spi_miso_oe
);
    localparam int LVL_W = $clog2(DEPTH) + 1;

    logic [2:0] pins_s;
    logic [FRAME_W-1:0] tx_head, rx_word;
    logic tx_pop, rx_push, urun_set;
    logic [LVL_W-1:0] tx_level;
    flags_t fq, fd;

    spi_slv_sync #(.W(3), .STAGES(2), .INIT(3'b010)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_sclk, spi_cs_n, spi_mosi}),
        .dout (pins_s)
    );

    spi_slv_engine u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (pins_s[2]),
        .sel_s       (!pins_s[1]),
        .sdi_s       (pins_s[0]),
        .phase       (cfg_cpha),
        .out_dis     (cfg_sdo_off),
        .tx_word     (tx_head),
        .tx_empty    (tx_empty),
        .tx_pop      (tx_pop),
        .rx_push     (rx_push),
        .rx_word     (rx_word),
        .underrun_set(urun_set),
        .sdo         (spi_miso),
        .sdo_en      (spi_miso_oe)
    );

    spi_slv_fifo #(.W(FRAME_W), .DEPTH(DEPTH)) u_txq (
        .clk  (clk),
        .rst_n(rst_n),
        .push (tx_wr),
        .wdata(tx_wdata),
        .pop  (tx_pop),
        .rdata(tx_head),
        .full (tx_full),
        .empty(tx_empty),
        .level(tx_level)
    );

    spi_slv_fifo #(.W(FRAME_W), .DEPTH(DEPTH)) u_rxq (
        .clk  (clk),
        .rst_n(rst_n),
        .push (rx_push),
        .wdata(rx_word),
        .pop  (rx_rd),
        .rdata(rx_rdata),
        .full (rx_full),
        .empty(rx_empty),
        .level(rx_level)
    );

    always_comb begin
        fd          = fq;
        fd.underrun = (fq.underrun && !sts_clr) || urun_set;
        fd.overrun  = (fq.overrun  && !sts_clr) || (rx_push && rx_full);
        fd.irq      = (fq.irq      && !sts_clr) || (rx_level >= LVL_W'(IRQ_LEVEL));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fq <= '0;
        else        fq <= fd;
    end

    assign err_underrun = fq.underrun;
    assign err_overrun  = fq.overrun;
    assign irq          = fq.irq;
endmodule

// File: rtl/spi_slave_fifo_chk.sv
module spi_slave_fifo_chk #(
    parameter int DEPTH     = 8,
    parameter int IRQ_LEVEL = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_sdo_off,
    input logic                   spi_cs_n,
    input logic                   spi_miso_oe,
    input logic                   tx_empty,
    input logic                   rx_full,
    input logic [$clog2(DEPTH):0] rx_level,
    input logic                   err_underrun,
    input logic                   err_overrun,
    input logic                   irq
);
    localparam int LVL_W = $clog2(DEPTH) + 1;

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_sdo_off) |-> !spi_miso_oe);

    assert_idle_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spi_cs_n, 3) |-> !spi_miso_oe);

    assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= LVL_W'(IRQ_LEVEL)) |=> irq);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= LVL_W'(DEPTH));

    assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $past(rx_full));

    assert_underrun_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_underrun) |-> $past(tx_empty));
endmodule

bind spi_slave_fifo spi_slave_fifo_chk #(.DEPTH(DEPTH), .IRQ_LEVEL(IRQ_LEVEL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_sdo_off (cfg_sdo_off),
    .spi_cs_n    (spi_cs_n),
    .spi_miso_oe (spi_miso_oe),
    .tx_empty    (tx_empty),
    .rx_full     (rx_full),
    .rx_level    (rx_level),
    .err_underrun(err_underrun),
    .err_overrun (err_overrun),
    .irq         (irq)
);

// File: tb/tb_spi_slave_fifo.sv
module tb_spi_slave_fifo;
    localparam int H     = 8;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_cpha = 1'b0, cfg_sdo_off = 1'b0;
    logic tx_wr = 1'b0, rx_rd = 1'b0, sts_clr = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic tx_full, tx_empty, rx_empty, rx_full, err_underrun, err_overrun, irq;
    logic [7:0] rx_rdata;
    logic [3:0] rx_level;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    byte unsigned txq[$], rxq[$];
    bit m_urun = 0, m_ovr = 0;

    always #2 clk = ~clk;

    spi_slave_fifo dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_tx(input byte unsigned v);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = v;
        @(negedge clk); tx_wr = 1'b0;
        if (txq.size() < DEPTH) txq.push_back(v);
    endtask

    task automatic clear_flags();
        @(negedge clk); sts_clr = 1'b1;
        @(negedge clk); sts_clr = 1'b0;
        m_urun = 0; m_ovr = 0;
    endtask

    task automatic cmp_state(input string req);
        check(rx_level == rxq.size(), req, rx_level, rxq.size());
        check(tx_empty == (txq.size() == 0), req, tx_empty, txq.size() == 0);
        check(err_underrun == m_urun, req, err_underrun, m_urun);
        check(err_overrun == m_ovr, req, err_overrun, m_ovr);
    endtask

    task automatic drain(input string req);
        while (rxq.size() > 0) begin
            byte unsigned e = rxq.pop_front();
            @(negedge clk);
            check(rx_rdata == e, req, rx_rdata, e);
            rx_rd = 1'b1;
            @(negedge clk); rx_rd = 1'b0;
        end
        ticks(1);
        check(rx_empty == 1'b1, req, rx_empty, 1);
    endtask

    // n frames under one select period; model applies the capture rules
    task automatic xfer(input int n, input bit ph, input byte unsigned base, input string req);
        spi_cs_n = 1'b0;
        ticks(H);
        for (int f = 0; f < n; f++) begin
            byte unsigned mo = base + 8'(f * 17);
            byte unsigned mi = 0;
            bit cap = ph || (f == 0);
            byte unsigned exp_mi = 0;
            if (cap) begin
                if (txq.size() == 0) m_urun = 1;
                else exp_mi = txq.pop_front();
            end
            for (int b = 7; b >= 0; b--) begin
                if (!ph) begin
                    spi_mosi = mo[b]; ticks(H);
                    mi[b] = spi_miso; spi_sclk = 1'b1; ticks(H);
                    spi_sclk = 1'b0;
                end else begin
                    spi_sclk = 1'b1; spi_mosi = mo[b]; ticks(H);
                    mi[b] = spi_miso; spi_sclk = 1'b0; ticks(H);
                end
            end
            ticks(H);
            if (cap) begin
                check(mi == exp_mi, req, mi, exp_mi);
                if (rxq.size() < DEPTH) rxq.push_back(mo);
                else m_ovr = 1;
            end
        end
        spi_cs_n = 1'b1;
        ticks(2 * H);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        ticks(5);
        // R1 reset state
        check(tx_empty && rx_empty && rx_level == 0, "R1", {tx_empty, rx_empty}, 3);
        check(!irq && !err_underrun && !err_overrun && !spi_miso_oe, "R1",
              {irq, err_underrun, err_overrun, spi_miso_oe}, 0);
        rst_n = 1'b1;
        ticks(3);

        // R2 leading phase, one byte per select
        push_tx(8'hA5); push_tx(8'h3C);
        xfer(1, 0, 8'h5A, "R2");
        xfer(1, 0, 8'hC3, "R2");
        cmp_state("R2");
        drain("R2");

        // R3 leading phase, held select captures only the first byte
        push_tx(8'h11); push_tx(8'h22);
        xfer(2, 0, 8'h81, "R3");
        cmp_state("R3");
        check(rx_level == 1, "R3", rx_level, 1);
        drain("R3");

        // R4/R5 trailing phase, held select back-to-back
        cfg_cpha = 1'b1;
        push_tx(8'h33); push_tx(8'h44); push_tx(8'h55);
        xfer(3, 1, 8'hDE, "R4");
        cmp_state("R4");
        check(irq == 1'b0, "R5", irq, 0);
        xfer(1, 1, 8'hEF, "R4");
        cmp_state("R4");
        check(irq == 1'b1, "R5", irq, 1);
        clear_flags();
        ticks(1);
        check(irq == 1'b1, "R5", irq, 1);
        drain("R4");
        check(irq == 1'b1, "R5", irq, 1);
        clear_flags();
        ticks(1);
        check(irq == 1'b0, "R10", irq, 0);

        // R6 underrun: empty transmit queue
        xfer(1, 1, 8'h77, "R6");
        cmp_state("R6");
        clear_flags();
        ticks(1);
        check(err_underrun == 1'b0, "R10", err_underrun, 0);

        // R7 overrun: ninth byte dropped
        for (int i = 0; i < 8; i++) push_tx(8'(8'h60 + i));
        xfer(8, 1, 8'h10, "R7");
        cmp_state("R7");
        check(rx_full == 1'b1, "R7", rx_full, 1);
        drain("R7");
        clear_flags();
        ticks(1);
        check(!err_overrun && !err_underrun && !irq, "R10",
              {err_overrun, err_underrun, irq}, 0);

        // R8/R9 output enable
        cfg_sdo_off = 1'b1; spi_cs_n = 1'b0; ticks(H);
        check(spi_miso_oe == 1'b0, "R8", spi_miso_oe, 0);
        spi_cs_n = 1'b1; ticks(H);
        cfg_sdo_off = 1'b0; spi_cs_n = 1'b0; ticks(H);
        check(spi_miso_oe == 1'b1, "R9", spi_miso_oe, 1);
        spi_cs_n = 1'b1; ticks(H);
        check(spi_miso_oe == 1'b0, "R9", spi_miso_oe, 0);

        // R11 push into full transmit queue is ignored
        for (int i = 0; i < 9; i++) push_tx(8'(8'hB0 + i));
        ticks(1);
        check(tx_full == 1'b1, "R11", tx_full, 1);
        xfer(8, 1, 8'h01, "R11");
        check(tx_empty == 1'b1, "R11", tx_empty, 1);
        cmp_state("R11");
        drain("R11");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule